// File: doc/BRIEF.md
# Two-Stream TDM Time-Slot Switch

This core is a non-blocking time-slot interchanger for two serial input links and two serial output links. Each link carries 32 byte-wide channels per frame, sent MSB first, with four core clocks per bit. Every received channel byte lands in a 64-entry data store. A 64-entry connection table, with one entry for each output link and channel, says what that output channel carries. It can be a byte copied from any input link and channel, a fixed byte held in the table (message mode), or nothing, with the output enable held low.

All memory traffic follows a fixed eight-step rotation inside each channel time. The rotation is the state machine `slot_e`. Its states are SL_LOAD0 and SL_LOAD1, which store the bytes received on links 0 and 1. SL_WIN0 and SL_WIN1 are the access windows. SL_LOOK0 and SL_LOOK1 read the table entry for the next channel of output links 0 and 1. SL_FETCH0 and SL_FETCH1 fetch the byte that entry selects. The transitions run SL_LOAD0→SL_LOAD1→SL_WIN0→SL_LOOK0→SL_FETCH0→SL_LOOK1→SL_WIN1→SL_FETCH1→SL_LOAD0. Each transition happens at the last clock of a bit period, and the channel count advances on FETCH1→LOAD0. A frame sync forces LOAD0 of channel 0.

A parallel host port with a request/acknowledge handshake is served in the windows. Its request goes through the states H_IDLE (request seen) → H_WAIT (a window opens) → H_ACK → H_IDLE. When the serial-bus mode is on, the windows instead write table entries taken from two control streams, and the host port is not served.

Top module: `tsi_switch`

## Requirements
- R1: When `frame_sync` is sampled high, the next cycle is clock 0 of bit period 0 of channel 0. A bit period lasts 4 clocks, a channel 8 bit periods (32 clocks) and a frame 32 channels (1024 clocks).
- R2: All serial links are MSB first. In bit period b a line carries bit 7-b of its byte. Inputs are sampled on the third clock of the bit period.
- R3: After reset every table entry is in connection mode with value 0x40 (tristate), so both `tx_oe` bits stay low and `host_ack` is low.
- R4: In connection mode, table byte bit 5 selects the source link and bits 4..0 the source channel. Output channel time T (counted in channel times since sync) carries the latest byte received on that source in a channel time Tin with Tin <= T-2.
- R5: In connection mode with bit 6 set, `tx_oe` of that link stays low for the whole channel.
- R6: An entry in message mode drives its own table byte on that output channel, with `tx_oe` high.
- R7: Host commands: 0 reads the table byte, 1 writes the entry in connection mode, 2 reads the data store, 3 writes the entry in message mode. `host_addr` bit 5 is the link and bits 4..0 the channel. `host_req` stays high until `host_ack`, which is a one-cycle pulse carrying `host_rdata` for reads.
- R8: A data-store read returns the byte most recently received on that link and channel in a channel time strictly before the one in which it is served.
- R9: With `sbus_mode` high, the byte received on control stream k in channel c is written into the table entry for output link k, channel c, in connection mode.
- R10: With `sbus_mode` high, no host request is served. A request held across the mode is served after the mode ends.
- R11: Bit 7 of a connection-mode byte has no effect on the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four cycles per serial bit |
| rst_n | input | 1 | Active-low reset |
| frame_sync | input | 1 | Frame alignment pulse |
| sbus_mode | input | 1 | Table loaded from control streams |
| rx_in | input | 2 | Serial input links |
| sbus_in | input | 2 | Serial control streams |
| host_req | input | 1 | Host request, held until acknowledge |
| host_cmd | input | 2 | Host command code |
| host_addr | input | 6 | Link bit and channel |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Host read byte |
| tx_out | output | 2 | Serial output links |
| tx_oe | output | 2 | Output enables for the links |

## Verification
Two pairs of functions share a cycle. The host window and the control-stream table write compete for the same rotation steps, and the bench provokes this by holding a host read pending across two frames of serial-bus mode. It then requires that no acknowledge appears while the mode is on and that the late read returns the byte the control stream wrote. At the channel boundary, the capture of the last received bit and the loading of the output shifter also fall in one edge. Routings that connect channel 31 to channels 0 and 1, and a channel to itself, check that each fetch sees exactly the bytes stored before it in the rotation.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_LINKS = 2;

    // rotation step inside one channel time
    typedef enum logic [2:0] {
        SL_LOAD0  = 3'd0,
        SL_LOAD1  = 3'd1,
        SL_WIN0   = 3'd2,
        SL_LOOK0  = 3'd3,
        SL_FETCH0 = 3'd4,
        SL_LOOK1  = 3'd5,
        SL_WIN1   = 3'd6,
        SL_FETCH1 = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        CMD_RD_TAB  = 2'd0,
        CMD_WR_CONN = 2'd1,
        CMD_RD_DATA = 2'd2,
        CMD_WR_MSG  = 2'd3
    } host_cmd_e;

    typedef enum logic [1:0] {
        H_IDLE = 2'd0,
        H_WAIT = 2'd1,
        H_ACK  = 2'd2
    } host_st_e;

    typedef struct packed {
        logic              msg;
        logic [BYTE_W-1:0] val;
    } tab_entry_t;

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int CH_W        = 5,
    parameter int CLK_PER_BIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    output slot_e           slot,
    output logic [CH_W-1:0] chan,
    output logic            act,
    output logic            smp,
    output logic            shift,
    output logic            last
);

    localparam int PH_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(CLK_PER_BIT - 1);
    localparam logic [PH_W-1:0] PH_MID = PH_W'(CLK_PER_BIT / 2);

    logic [PH_W-1:0] ph;
    slot_e           slot_nx;

    always_comb begin
        slot_nx = slot;
        unique case (slot)
            SL_LOAD0:  slot_nx = SL_LOAD1;
            SL_LOAD1:  slot_nx = SL_WIN0;
            SL_WIN0:   slot_nx = SL_LOOK0;
            SL_LOOK0:  slot_nx = SL_FETCH0;
            SL_FETCH0: slot_nx = SL_LOOK1;
            SL_LOOK1:  slot_nx = SL_WIN1;
            SL_WIN1:   slot_nx = SL_FETCH1;
            SL_FETCH1: slot_nx = SL_LOAD0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            slot <= SL_LOAD0;
            chan <= '0;
        end else if (frame_sync) begin
            ph   <= '0;
            slot <= SL_LOAD0;
            chan <= '0;
        end else if (ph == PH_MAX) begin
            ph   <= '0;
            slot <= slot_nx;
            if (slot == SL_FETCH1) chan <= chan + 1'b1;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    always_comb begin
        act   = (ph == '0);
        smp   = (ph == PH_MID);
        shift = (ph == PH_MAX);
        last  = (ph == PH_MAX) && (slot == SL_FETCH1);
    end

    // R1
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (slot == SL_LOAD0 && chan == '0 && act));

    // R1
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && !shift) |=> $stable(slot));

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              smp,
    input  logic              last,
    output logic [BYTE_W-1:0] byte_q
);

    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            byte_q <= '0;
        end else begin
            if (smp)  sh     <= {sh[BYTE_W-2:0], din};
            if (last) byte_q <= sh;
        end
    end

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              load_oe,
    output logic              dout,
    output logic              oe
);

    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (load) begin
            sh <= load_byte;
            oe <= load_oe;
        end else if (shift) begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign dout = sh[BYTE_W-1];

    // R5
    oe_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe) |-> $past(load));

endmodule

// File: rtl/tsi_host.sv
module tsi_host
    import tsi_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        cmd,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              window,
    output logic              go,
    output logic              ack,
    output host_cmd_e         cmd_q,
    output logic [AW-1:0]     addr_q,
    output logic [BYTE_W-1:0] wdata_q
);

    host_st_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            H_IDLE:  if (req)    st_nx = H_WAIT;
            H_WAIT:  if (window) st_nx = H_ACK;
            H_ACK:               st_nx = H_IDLE;
            default:             st_nx = H_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= H_IDLE;
            cmd_q   <= CMD_RD_TAB;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st <= st_nx;
            if (st == H_IDLE && req) begin
                cmd_q   <= host_cmd_e'(cmd);
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    always_comb begin
        go  = (st == H_WAIT) && window;
        ack = (st == H_ACK);
    end

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == H_WAIT && !window) |=> (st == H_WAIT));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int CH_W        = 5,
    parameter int CLK_PER_BIT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_sync,
    input  logic        sbus_mode,
    input  logic [1:0]  rx_in,
    input  logic [1:0]  sbus_in,
    input  logic        host_req,
    input  logic [1:0]  host_cmd,
    input  logic [5:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic        host_ack,
    output logic [7:0]  host_rdata,
    output logic [1:0]  tx_out,
    output logic [1:0]  tx_oe
);

    localparam int AW      = CH_W + 1;
    localparam int NUM_ENT = 1 << AW;
    localparam int SRC_BIT = CH_W;
    localparam int ODE_BIT = CH_W + 1;
    localparam logic [BYTE_W-1:0] TAB_RST = BYTE_W'(1) << ODE_BIT;

    slot_e            slot;
    logic [CH_W-1:0]  chan, prev_ch, next_ch;
    logic             act, smp, shift, last;
    logic             window, host_go, win_link;
    host_cmd_e        h_cmd;
    logic [AW-1:0]    h_addr;
    logic [BYTE_W-1:0] h_wdata;

    logic [BYTE_W-1:0] rx_byte  [NUM_LINKS];
    logic [BYTE_W-1:0] ctl_byte [NUM_LINKS];
    logic [BYTE_W-1:0] fetch_byte [NUM_LINKS];
    logic              fetch_oe   [NUM_LINKS];
    tab_entry_t        look       [NUM_LINKS];

    logic [BYTE_W-1:0] dmem [NUM_ENT];
    tab_entry_t        tab  [NUM_ENT];

    tsi_timing #(.CH_W(CH_W), .CLK_PER_BIT(CLK_PER_BIT)) u_timing (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .slot(slot), .chan(chan), .act(act), .smp(smp),
        .shift(shift), .last(last)
    );

    assign prev_ch  = chan - 1'b1;
    assign next_ch  = chan + 1'b1;
    assign win_link = (slot == SL_WIN1);
    assign window   = act && (slot == SL_WIN0 || slot == SL_WIN1) && !sbus_mode;

    tsi_host #(.AW(AW)) u_host (
        .clk(clk), .rst_n(rst_n), .req(host_req), .cmd(host_cmd),
        .addr(host_addr), .wdata(host_wdata), .window(window),
        .go(host_go), .ack(host_ack), .cmd_q(h_cmd),
        .addr_q(h_addr), .wdata_q(h_wdata)
    );

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        tsi_rx u_rx_dat (
            .clk(clk), .rst_n(rst_n), .din(rx_in[g]), .smp(smp),
            .last(last), .byte_q(rx_byte[g])
        );
        tsi_rx u_rx_ctl (
            .clk(clk), .rst_n(rst_n), .din(sbus_in[g]), .smp(smp),
            .last(last), .byte_q(ctl_byte[g])
        );
        tsi_tx u_tx (
            .clk(clk), .rst_n(rst_n), .load(last), .shift(shift),
            .load_byte(fetch_byte[g]), .load_oe(fetch_oe[g]),
            .dout(tx_out[g]), .oe(tx_oe[g])
        );
    end

    // memory rotation: one access step per bit period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                dmem[i] <= '0;
                tab[i]  <= '{msg: 1'b0, val: TAB_RST};
            end
            for (int k = 0; k < NUM_LINKS; k++) begin
                look[k]       <= '{msg: 1'b0, val: TAB_RST};
                fetch_byte[k] <= '0;
                fetch_oe[k]   <= 1'b0;
            end
            host_rdata <= '0;
        end else if (act) begin
            unique case (slot)
                SL_LOAD0: dmem[{1'b0, prev_ch}] <= rx_byte[0];
                SL_LOAD1: dmem[{1'b1, prev_ch}] <= rx_byte[1];
                SL_WIN0, SL_WIN1: begin
                    if (sbus_mode) begin
                        tab[{win_link, prev_ch}] <= '{msg: 1'b0, val: ctl_byte[win_link]};
                    end else if (host_go) begin
                        unique case (h_cmd)
                            CMD_RD_TAB:  host_rdata   <= tab[h_addr].val;
                            CMD_WR_CONN: tab[h_addr]  <= '{msg: 1'b0, val: h_wdata};
                            CMD_RD_DATA: host_rdata   <= dmem[h_addr];
                            CMD_WR_MSG:  tab[h_addr]  <= '{msg: 1'b1, val: h_wdata};
                        endcase
                    end
                end
                SL_LOOK0: look[0] <= tab[{1'b0, next_ch}];
                SL_LOOK1: look[1] <= tab[{1'b1, next_ch}];
                SL_FETCH0: begin
                    fetch_byte[0] <= look[0].msg ? look[0].val : dmem[look[0].val[SRC_BIT:0]];
                    fetch_oe[0]   <= look[0].msg | ~look[0].val[ODE_BIT];
                end
                SL_FETCH1: begin
                    fetch_byte[1] <= look[1].msg ? look[1].val : dmem[look[1].val[SRC_BIT:0]];
                    fetch_oe[1]   <= look[1].msg | ~look[1].val[ODE_BIT];
                end
            endcase
        end
    end

    // R10
    no_host_in_sbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !$past(sbus_mode));

    // R7
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $past(host_req));

endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       sbus_mode = 1'b0;
    logic [1:0] rx_in = '0;
    logic [1:0] sbus_in = '0;
    logic       host_req = 1'b0;
    logic [1:0] host_cmd = '0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_ack;
    logic [7:0] host_rdata;
    logic [1:0] tx_out;
    logic [1:0] tx_oe;

    always #5 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .sbus_mode(sbus_mode),
        .rx_in(rx_in), .sbus_in(sbus_in), .host_req(host_req), .host_cmd(host_cmd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .tx_out(tx_out), .tx_oe(tx_oe)
    );

    int          cyc = -1;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          chk_en = 1'b0;
    bit          done = 1'b0;
    string       phase_tag = "";
    int unsigned seed_k;
    logic [7:0]  cfg_byte [2][32];
    bit          cfg_msg  [2][32];
    logic [7:0]  sb_cfg   [2][32];

    always @(posedge clk) begin
        if (frame_sync) cyc <= 0;
        else if (cyc >= 0) cyc <= cyc + 1;
    end

    function automatic logic [7:0] gen(int fr, int s, int c);
        return 8'((fr * 73 + s * 151 + c * 29 + int'(seed_k & 32'hFFFF)) ^ (fr * 5));
    endfunction

    // R4: latest input slot Tin with Tin <= T-2 for source channel c
    function automatic logic [7:0] src_byte(int t, int s, int c);
        return gen((t - 2 - c) / 32, s, c);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_chan(int l, int d, int t, logic [7:0] ob, bit on, bit off);
        logic [7:0] e;
        string tag;
        if (cfg_msg[l][d]) begin
            tag = (phase_tag != "") ? phase_tag : "R6";
            check(on && ob == cfg_byte[l][d], tag, {on, ob}, {1'b1, cfg_byte[l][d]});
        end else if (cfg_byte[l][d][6]) begin
            tag = (phase_tag != "") ? phase_tag : "R5";
            check(off, tag, {on, off}, 2'b01);
        end else begin
            e = src_byte(t, int'(cfg_byte[l][d][5]), int'(cfg_byte[l][d][4:0]));
            tag = (phase_tag != "") ? phase_tag : (cfg_byte[l][d][7] ? "R11" : "R4");
            check(on && ob == e, tag, {on, ob}, {1'b1, e});
        end
    endtask

    // stimulus driver and output monitor, R2 bit order
    initial begin
        logic [7:0] ob [2];
        bit         on [2];
        bit         off [2];
        logic [7:0] v;
        wait (cyc >= 0);
        forever begin
            @(negedge clk);
            begin
                int n, ph, b, ts, t;
                n = cyc; ph = n % 4; b = (n / 4) % 8; ts = (n / 32) % 32; t = n / 32;
                for (int s = 0; s < 2; s++) begin
                    v = gen(t / 32, s, ts);
                    rx_in[s] = v[7 - b];
                    v = sb_cfg[s][ts];
                    sbus_in[s] = v[7 - b];
                end
                if (ph == 2) begin
                    for (int l = 0; l < 2; l++) begin
                        if (b == 0) begin on[l] = 1'b1; off[l] = 1'b1; end
                        ob[l][7 - b] = tx_out[l];
                        on[l]  = on[l] & tx_oe[l];
                        off[l] = off[l] & !tx_oe[l];
                        if (b == 7 && chk_en) check_chan(l, ts, t, ob[l], on[l], off[l]);
                    end
                end
            end
        end
    end

    task automatic host_op(input logic [1:0] c, input logic [5:0] a, input logic [7:0] w,
                           output logic [7:0] r, output int tack);
        @(negedge clk);
        host_cmd = c; host_addr = a; host_wdata = w; host_req = 1'b1;
        do @(negedge clk); while (host_ack !== 1'b1);
        r = host_rdata;
        tack = cyc / 32;
        host_req = 1'b0;
    endtask

    task automatic frame_start();
        do @(negedge clk); while (cyc % 1024 != 0);
    endtask

    task automatic check_frame();
        frame_start(); frame_start(); frame_start();
        chk_en = 1'b1;
        frame_start();
        chk_en = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        int         tk;
        bit         saw;
        int         acks;
        void'($urandom(32'd4242));
        seed_k = $urandom;
        for (int l = 0; l < 2; l++)
            for (int d = 0; d < 32; d++) begin
                cfg_byte[l][d] = 8'h40; cfg_msg[l][d] = 1'b0; sb_cfg[l][d] = 8'h00;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check(tx_oe == 2'b00, "R3", tx_oe, 0);
        check(host_ack == 1'b0, "R3", host_ack, 0);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        saw = 1'b0;
        repeat (1100) begin
            @(negedge clk);
            if (tx_oe != 2'b00) saw = 1'b1;
        end
        check(!saw, "R3", saw, 0);
        // R1 sync re-alignment check through bench counter
        check(cyc >= 1100, "R1", cyc, 1100);

        for (int rnd = 0; rnd < 6; rnd++) begin
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < 32; d++) begin
                    int x;
                    x = $urandom % 10;
                    if (x < 2) begin
                        cfg_msg[l][d] = 1'b1; cfg_byte[l][d] = 8'($urandom);
                    end else if (x < 3) begin
                        cfg_msg[l][d] = 1'b0;
                        cfg_byte[l][d] = {1'($urandom), 1'b1, 6'($urandom)};
                    end else begin
                        cfg_msg[l][d] = 1'b0;
                        cfg_byte[l][d] = {1'($urandom), 1'b0, 6'($urandom)};
                    end
                end
            if (rnd == 0) begin
                // directed wrap and self-routing corners
                cfg_msg[0][0]  = 1'b0; cfg_byte[0][0]  = {2'b00, 1'b1, 5'd31};
                cfg_msg[0][1]  = 1'b0; cfg_byte[0][1]  = {2'b00, 1'b1, 5'd31};
                cfg_msg[0][31] = 1'b0; cfg_byte[0][31] = {2'b00, 1'b0, 5'd31};
                cfg_msg[1][0]  = 1'b0; cfg_byte[1][0]  = {2'b10, 1'b0, 5'd0};
                cfg_msg[1][31] = 1'b0; cfg_byte[1][31] = {2'b00, 1'b1, 5'd30};
                cfg_msg[1][2]  = 1'b0; cfg_byte[1][2]  = {2'b00, 1'b0, 5'd0};
            end
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < 32; d++)
                    host_op(cfg_msg[l][d] ? 2'd3 : 2'd1, {1'(l), 5'(d)}, cfg_byte[l][d], r, tk);
            check_frame();
            for (int k = 0; k < 4; k++) begin
                int l, d;
                l = $urandom % 2; d = $urandom % 32;
                host_op(2'd0, {1'(l), 5'(d)}, 8'h00, r, tk);
                check(r == cfg_byte[l][d], "R7", r, cfg_byte[l][d]);
            end
            for (int k = 0; k < 4; k++) begin
                int s, c;
                logic [7:0] e;
                s = $urandom % 2; c = (k == 0) ? 31 : ($urandom % 32);
                host_op(2'd2, {1'(s), 5'(c)}, 8'h00, r, tk);
                e = gen((tk - 1 - c) / 32, s, c);
                check(r == e, "R8", r, e);
            end
        end

        // serial-bus mode: control streams load the table, host is held off
        for (int l = 0; l < 2; l++)
            for (int d = 0; d < 32; d++)
                sb_cfg[l][d] = {1'b0, 1'(($urandom % 5) == 0), 6'($urandom)};
        frame_start();
        sbus_mode = 1'b1;
        host_cmd = 2'd0; host_addr = {1'b0, 5'd5}; host_wdata = 8'h00; host_req = 1'b1;
        acks = 0;
        repeat (2100) begin
            @(negedge clk);
            if (host_ack) acks++;
        end
        check(acks == 0, "R10", acks, 0);
        do @(negedge clk); while (cyc % 1024 != 64);
        sbus_mode = 1'b0;
        do @(negedge clk); while (host_ack !== 1'b1);
        r = host_rdata;
        host_req = 1'b0;
        check(r == sb_cfg[0][5], "R10", r, sb_cfg[0][5]);
        for (int l = 0; l < 2; l++)
            for (int d = 0; d < 32; d++) begin
                cfg_msg[l][d] = 1'b0; cfg_byte[l][d] = sb_cfg[l][d];
            end
        host_op(2'd0, {1'b1, 5'd31}, 8'h00, r, tk);
        check(r == sb_cfg[1][31], "R9", r, sb_cfg[1][31]);
        phase_tag = "R9";
        check_frame();
        phase_tag = "";

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule